// File: doc/BRIEF.md
# Channel-Mapped Prioritized Interrupt Controller

This block collects up to 64 interrupt sources and drives two host request lines: a fast line and a normal line. Each source is detected as a rising edge, a falling edge, an active-high level or an active-low level. The detected event is latched in a per-source status bit and then gated by a per-source enable. Software assigns every source to one of 32 priority channels. Channels 0 and 1 feed the fast line, and channels 2 to 31 feed the normal line.

For each line the block picks one winning source among the pending sources routed to it. The winner is the source on the lowest channel, and the lowest source number breaks a tie. Software reads the winner from a per-line index register. Each line has its own enable, and a global enable sits above both.

Software reaches the block over a simple register bus with 32-bit words. Single status bits and single enable bits are changed by writing a source number to an index register, so no read-modify-write is needed. Whole groups of 32 bits are cleared by writing ones to a word register. Read data comes back one cycle after the read request, together with a valid strobe.

Top module: `intc_chanmap`

## Requirements
- R1: Writing a source number n to offset 0x004 clears status bit n in the following cycle and leaves every other status bit unchanged.
- R2: Writing n to offset 0x008 sets enable bit n, and writing n to offset 0x00C clears it. All other enable bits keep their value. A value at or above the source count changes nothing.
- R3: Detection is selected by a polarity bit (offset 0x080 + 4*g) and a type bit (offset 0x0A0 + 4*g), where g is the 32-source group. Type 1 with polarity 1 detects a rising edge. Type 1 with polarity 0 detects a falling edge. Type 0 with polarity 1 detects a high level. Type 0 with polarity 0 detects a low level. Inputs pass through a two-flop synchronizer first.
- R4: For group g, status is read at 0x040 + 4*g and enables at 0x060 + 4*g. Writing a word to either offset clears every bit that is one in the written data. Bits that are zero in the data keep their value.
- R5: The status of an edge source stays set after the input returns to idle, until software clears it. The status of a level source follows the active level on every cycle.
- R6: Channel-map word w, at offset 0x100 + 4*w, holds the channels of sources 4w to 4w+3. Source 4w sits in bits 4:0, and each following source sits 8 bits higher. The upper three bits of each byte read as zero.
- R7: A pending source is one whose status and enable are both set. Among the pending sources of a line, the lowest channel wins, and on equal channels the lowest source number wins.
- R8: Channels 0 and 1 are served by the fast line (fiq_o). Channels 2 to 31 are served by the normal line (irq_o).
- R9: A line is high only while it has a pending source, its own host enable is set and the global enable (offset 0x000, bit 0) is set. Host enables are set and cleared by writing host index 0 (fast) or 1 (normal) to 0x010 and 0x014, and they read back at 0x018, bits 1:0.
- R10: The fast index register (0x01C) and the normal index register (0x020) return the winning source number in bits 7:0. Bit 31 is set, with the other bits zero, when the line has no pending source.
- R11: After reset, every enable, status bit, polarity bit, type bit and both host lines are zero, and every channel-map entry holds channel 15.
- R12: The host lines are registered, so each one changes on the clock edge after its inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt source inputs, asynchronous to clk |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High one cycle after a read request |
| fiq_o | output | 1 | Fast host request line |
| irq_o | output | 1 | Normal host request line |

## Verification
The hardest case to reach from the ports is a channel tie that coexists with a lower-numbered source on a worse channel, while the enable gates change around it. Level-high sources are used for this case because their status stays set for as long as the input is held. That lets the bench rewrite the channel map, the enables and the host gates underneath a stable pending set. Dropping one input of the tied pair then shows whether the next winner is chosen by channel rather than by source number. A second fast source is then placed on channel 0 to displace the channel-1 winner.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Byte offsets of the control registers on the register bus
    localparam logic [11:0] A_GLOBAL       = 12'h000;
    localparam logic [11:0] A_STAT_IDX_CLR = 12'h004;
    localparam logic [11:0] A_EN_IDX_SET   = 12'h008;
    localparam logic [11:0] A_EN_IDX_CLR   = 12'h00C;
    localparam logic [11:0] A_HEN_IDX_SET  = 12'h010;
    localparam logic [11:0] A_HEN_IDX_CLR  = 12'h014;
    localparam logic [11:0] A_HEN          = 12'h018;
    localparam logic [11:0] A_PRI_FAST     = 12'h01C;
    localparam logic [11:0] A_PRI_NORM     = 12'h020;

    // Per-group word registers (one word per 32 sources)
    localparam logic [11:0] A_STAT_BASE    = 12'h040;
    localparam logic [11:0] A_EN_BASE      = 12'h060;
    localparam logic [11:0] A_POL_BASE     = 12'h080;
    localparam logic [11:0] A_TYPE_BASE    = 12'h0A0;

    // Channel map words (four sources per word)
    localparam logic [11:0] A_MAP_BASE     = 12'h100;

    // Result of one host line's priority search
    typedef struct packed {
        logic       valid;
        logic [7:0] src;
    } win_t;

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic pol_i,
    input  logic typ_i,
    input  logic clr_i,
    output logic stat_o
);
    logic s1, s2, lvl_prev;
    logic lvl;

    // Polarity folds every mode onto an "active" level
    assign lvl = pol_i ? s2 : ~s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1       <= 1'b0;
            s2       <= 1'b0;
            lvl_prev <= 1'b0;
            stat_o   <= 1'b0;
        end else begin
            s1       <= src_i;
            s2       <= s1;
            lvl_prev <= lvl;
            if (clr_i)
                stat_o <= 1'b0;
            else if (typ_i)
                stat_o <= stat_o | (lvl & ~lvl_prev);
            else
                stat_o <= lvl;
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int SRC_N  = 64,
    parameter int CHAN_W = 5,
    parameter int CH_LO  = 0,
    parameter int CH_HI  = 1
) (
    input  logic [SRC_N-1:0]        pend_i,
    input  logic [SRC_N*CHAN_W-1:0] map_i,
    output intc_pkg::win_t          win_o
);
    logic [CHAN_W-1:0] best;

    // Ascending scan with strict compare: ties keep the lower source
    always_comb begin
        win_o = '0;
        best  = '1;
        for (int s = 0; s < SRC_N; s++) begin
            if (pend_i[s]
                && int'(map_i[s*CHAN_W +: CHAN_W]) >= CH_LO
                && int'(map_i[s*CHAN_W +: CHAN_W]) <= CH_HI
                && (!win_o.valid || map_i[s*CHAN_W +: CHAN_W] < best)) begin
                win_o.valid = 1'b1;
                win_o.src   = 8'(s);
                best        = map_i[s*CHAN_W +: CHAN_W];
            end
        end
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int SRC_N   = 64,
    parameter int CHAN_W  = 5,
    parameter int HOST_N  = 2,
    parameter int MAP_RST = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_i,
    input  logic                       wr_i,
    input  logic [11:0]                addr_i,
    input  logic [31:0]                wdata_i,
    input  logic [SRC_N-1:0]           status_i,
    input  win_t [HOST_N-1:0]          win_i,
    output logic [31:0]                rdata_o,
    output logic                       rvalid_o,
    output logic [SRC_N-1:0]           en_o,
    output logic [SRC_N-1:0]           pol_o,
    output logic [SRC_N-1:0]           typ_o,
    output logic [SRC_N*CHAN_W-1:0]    map_o,
    output logic                       glob_o,
    output logic [HOST_N-1:0]          hen_o,
    output logic [SRC_N-1:0]           clr_o
);
    localparam int NGRP  = SRC_N / 32;
    localparam int NMAP  = SRC_N / 4;
    localparam int IDX_W = $clog2(SRC_N);
    localparam int HID_W = (HOST_N > 1) ? $clog2(HOST_N) : 1;

    logic              wr_go, rd_go, idx_ok, hidx_ok;
    logic [IDX_W-1:0]  idx;
    logic [HID_W-1:0]  hidx;
    logic [CHAN_W-1:0] map_q [SRC_N];
    logic [31:0]       rd_d;

    assign wr_go   = sel_i & wr_i;
    assign rd_go   = sel_i & ~wr_i;
    assign idx     = wdata_i[IDX_W-1:0];
    assign hidx    = wdata_i[HID_W-1:0];
    assign idx_ok  = (wdata_i < 32'(SRC_N));
    assign hidx_ok = (wdata_i < 32'(HOST_N));

    for (genvar s = 0; s < SRC_N; s++) begin : g_map_out
        assign map_o[s*CHAN_W +: CHAN_W] = map_q[s];
    end

    // Status clear strobes: single index or word of ones
    always_comb begin
        clr_o = '0;
        if (wr_go) begin
            if (addr_i == A_STAT_IDX_CLR && idx_ok)
                clr_o[idx] = 1'b1;
            for (int g = 0; g < NGRP; g++)
                if (addr_i == 12'(A_STAT_BASE + 4*g))
                    clr_o[g*32 +: 32] = wdata_i;
        end
    end

    // Writable state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_o <= 1'b0;
            hen_o  <= '0;
            en_o   <= '0;
            pol_o  <= '0;
            typ_o  <= '0;
            for (int s = 0; s < SRC_N; s++)
                map_q[s] <= CHAN_W'(MAP_RST);
        end else if (wr_go) begin
            if (addr_i == A_GLOBAL)
                glob_o <= wdata_i[0];
            if (addr_i == A_EN_IDX_SET && idx_ok)
                en_o[idx] <= 1'b1;
            if (addr_i == A_EN_IDX_CLR && idx_ok)
                en_o[idx] <= 1'b0;
            if (addr_i == A_HEN_IDX_SET && hidx_ok)
                hen_o[hidx] <= 1'b1;
            if (addr_i == A_HEN_IDX_CLR && hidx_ok)
                hen_o[hidx] <= 1'b0;
            for (int g = 0; g < NGRP; g++) begin
                if (addr_i == 12'(A_EN_BASE + 4*g))
                    en_o[g*32 +: 32] <= en_o[g*32 +: 32] & ~wdata_i;
                if (addr_i == 12'(A_POL_BASE + 4*g))
                    pol_o[g*32 +: 32] <= wdata_i;
                if (addr_i == 12'(A_TYPE_BASE + 4*g))
                    typ_o[g*32 +: 32] <= wdata_i;
            end
            for (int w = 0; w < NMAP; w++)
                if (addr_i == 12'(A_MAP_BASE + 4*w))
                    for (int j = 0; j < 4; j++)
                        map_q[4*w+j] <= wdata_i[8*j +: CHAN_W];
        end
    end

    // Read mux
    always_comb begin
        rd_d = '0;
        if (addr_i == A_GLOBAL)
            rd_d[0] = glob_o;
        if (addr_i == A_HEN)
            rd_d[HOST_N-1:0] = hen_o;
        if (addr_i == A_PRI_FAST)
            rd_d = {~win_i[0].valid, 23'd0, win_i[0].src};
        if (addr_i == A_PRI_NORM)
            rd_d = {~win_i[HOST_N-1].valid, 23'd0, win_i[HOST_N-1].src};
        for (int g = 0; g < NGRP; g++) begin
            if (addr_i == 12'(A_STAT_BASE + 4*g)) rd_d = status_i[g*32 +: 32];
            if (addr_i == 12'(A_EN_BASE + 4*g))   rd_d = en_o[g*32 +: 32];
            if (addr_i == 12'(A_POL_BASE + 4*g))  rd_d = pol_o[g*32 +: 32];
            if (addr_i == 12'(A_TYPE_BASE + 4*g)) rd_d = typ_o[g*32 +: 32];
        end
        for (int w = 0; w < NMAP; w++)
            if (addr_i == 12'(A_MAP_BASE + 4*w))
                for (int j = 0; j < 4; j++)
                    rd_d[8*j +: CHAN_W] = map_q[4*w+j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= rd_go;
            if (rd_go)
                rdata_o <= rd_d;
        end
    end
endmodule

// File: rtl/intc_chanmap.sv
module intc_chanmap #(
    parameter int SRC_N      = 64,
    parameter int CHAN_N     = 32,
    parameter int FAST_CHANS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_i,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    output logic             fiq_o,
    output logic             irq_o
);
    localparam int CHAN_W = $clog2(CHAN_N);
    localparam int HOST_N = 2;

    logic [SRC_N-1:0]        status_vec, en_vec, pol_vec, typ_vec, clr_vec, pend_vec;
    logic [SRC_N*CHAN_W-1:0] map_flat;
    logic                    glob_en;
    logic [HOST_N-1:0]       host_en, win_valid, line_q;
    intc_pkg::win_t [HOST_N-1:0] win;

    intc_regs #(
        .SRC_N(SRC_N), .CHAN_W(CHAN_W), .HOST_N(HOST_N), .MAP_RST(15)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .status_i(status_vec), .win_i(win),
        .rdata_o(bus_rdata), .rvalid_o(bus_rvalid),
        .en_o(en_vec), .pol_o(pol_vec), .typ_o(typ_vec), .map_o(map_flat),
        .glob_o(glob_en), .hen_o(host_en), .clr_o(clr_vec)
    );

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        intc_src_cell u_cell (
            .clk(clk), .rst_n(rst_n), .src_i(src_i[s]),
            .pol_i(pol_vec[s]), .typ_i(typ_vec[s]), .clr_i(clr_vec[s]),
            .stat_o(status_vec[s])
        );
    end

    assign pend_vec = status_vec & en_vec;

    for (genvar h = 0; h < HOST_N; h++) begin : g_host
        localparam int LO = (h == 0) ? 0 : FAST_CHANS;
        localparam int HI = (h == 0) ? FAST_CHANS - 1 : CHAN_N - 1;
        intc_prio #(
            .SRC_N(SRC_N), .CHAN_W(CHAN_W), .CH_LO(LO), .CH_HI(HI)
        ) u_prio (
            .pend_i(pend_vec), .map_i(map_flat), .win_o(win[h])
        );
        assign win_valid[h] = win[h].valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            line_q <= '0;
        else
            line_q <= win_valid & host_en & {HOST_N{glob_en}};
    end

    assign fiq_o = line_q[0];
    assign irq_o = line_q[1];
endmodule

// File: rtl/intc_chanmap_chk.sv
module intc_chanmap_chk #(
    parameter int SRC_N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [SRC_N-1:0] status,
    input  logic [SRC_N-1:0] en,
    input  logic             glob_en,
    input  logic [1:0]       host_en,
    input  logic [1:0]       win_valid,
    input  logic             fiq_o,
    input  logic             irq_o
);
    import intc_pkg::*;
    localparam int IDX_W = $clog2(SRC_N);

    logic idx_wr;
    assign idx_wr = bus_sel && bus_wr && (bus_wdata < 32'(SRC_N));

    AST_STAT_IDX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && bus_addr == A_STAT_IDX_CLR) |=> !status[$past(bus_wdata[IDX_W-1:0])]); // R1
    AST_EN_IDX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && bus_addr == A_EN_IDX_SET) |=> en[$past(bus_wdata[IDX_W-1:0])]); // R2
    AST_EN_IDX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && bus_addr == A_EN_IDX_CLR) |=> !en[$past(bus_wdata[IDX_W-1:0])]); // R2
    AST_FIQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(glob_en && host_en[0])); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(glob_en && host_en[1])); // R9
    AST_FIQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(win_valid[0])); // R12
    AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(win_valid[1])); // R12
endmodule

bind intc_chanmap intc_chanmap_chk #(.SRC_N(SRC_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_vec),
    .en(en_vec), .glob_en(glob_en), .host_en(host_en),
    .win_valid(win_valid), .fiq_o(fiq_o), .irq_o(irq_o)
);

// File: tb/sim_intc_chanmap.sv
module sim_intc_chanmap;
    import intc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic        sel, wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid, fiq, irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    intc_chanmap u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_rvalid(rvalid), .fiq_o(fiq), .irq_o(irq)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    // Driver: issue a read and queue what must come back
    task automatic read_expect(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        sel = 1'b0;
    endtask

    // Monitor: compare each returned word against the queue head
    always @(negedge clk) begin
        if (rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL unexpected read data: got %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_err++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_pins(input logic ef, input logic ei, input string t);
        repeat (2) @(negedge clk);
        n_chk++;
        if (fiq !== ef || irq !== ei) begin
            n_err++;
            $display("FAIL %s: got fiq=%b irq=%b expected fiq=%b irq=%b", t, fiq, irq, ef, ei);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        src = ~64'h0000_0300_0000_0F20;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R11 reset state
        read_expect(A_GLOBAL, 32'h0, "R11 global");
        read_expect(A_EN_BASE, 32'h0, "R11 enable g0");
        read_expect(A_EN_BASE + 12'h4, 32'h0, "R11 enable g1");
        read_expect(A_MAP_BASE, 32'h0F0F0F0F, "R11 map w0");
        read_expect(A_MAP_BASE + 12'h3C, 32'h0F0F0F0F, "R11 map w15");
        read_expect(A_HEN, 32'h0, "R11 host enables");
        read_expect(A_PRI_NORM, 32'h8000_0000, "R11 R10 none");
        check_pins(1'b0, 1'b0, "R11 lines");

        // Configure: 5 rising, 6 falling, 8..11 and 40,41 high level
        bus_write(A_TYPE_BASE, 32'h60);
        bus_write(A_POL_BASE, 32'hF20);
        bus_write(A_POL_BASE + 12'h4, 32'h300);
        settle();
        read_expect(A_STAT_BASE, 32'h20, "R5 latched across config");
        bus_write(A_STAT_BASE, 32'hFFFF_FFFF);
        read_expect(A_STAT_BASE, 32'h0, "R4 status word clear");

        src[5] = 1'b1; settle();
        read_expect(A_STAT_BASE, 32'h20, "R3 rising edge");
        src[5] = 1'b0; settle();
        read_expect(A_STAT_BASE, 32'h20, "R5 edge stays latched");
        src[6] = 1'b0; settle();
        read_expect(A_STAT_BASE, 32'h60, "R3 falling edge");
        bus_write(A_STAT_IDX_CLR, 32'd5);
        read_expect(A_STAT_BASE, 32'h40, "R1 index clear");
        src[8] = 1'b1; settle();
        read_expect(A_STAT_BASE, 32'h140, "R3 high level");
        src[8] = 1'b0; settle();
        read_expect(A_STAT_BASE, 32'h40, "R5 level follows input");
        src[7] = 1'b0; settle();
        read_expect(A_STAT_BASE, 32'hC0, "R3 low level");
        src[7] = 1'b1; settle();
        bus_write(A_STAT_IDX_CLR, 32'd6);
        read_expect(A_STAT_BASE, 32'h0, "R1 index clear second");

        // Enables
        bus_write(A_EN_IDX_SET, 32'd8);
        bus_write(A_EN_IDX_SET, 32'd9);
        bus_write(A_EN_IDX_SET, 32'd40);
        read_expect(A_EN_BASE, 32'h300, "R2 index set g0");
        read_expect(A_EN_BASE + 12'h4, 32'h100, "R2 index set g1");
        bus_write(A_EN_IDX_CLR, 32'd9);
        bus_write(A_EN_IDX_SET, 32'd64);
        read_expect(A_EN_BASE, 32'h100, "R2 index clear and out of range");
        bus_write(A_EN_BASE, 32'hFFFF_FFFF);
        read_expect(A_EN_BASE, 32'h0, "R4 enable word clear");
        read_expect(A_EN_BASE + 12'h4, 32'h100, "R4 other group kept");

        // Channel map and priority
        bus_write(A_MAP_BASE + 12'h8, 32'hE5E4_E5E6);
        read_expect(A_MAP_BASE + 12'h8, 32'h0504_0506, "R6 map byte layout");
        bus_write(A_EN_IDX_SET, 32'd8);
        bus_write(A_EN_IDX_SET, 32'd9);
        bus_write(A_EN_IDX_SET, 32'd11);
        src[8] = 1'b1; src[9] = 1'b1; src[11] = 1'b1; settle();
        read_expect(A_PRI_NORM, 32'h9, "R7 tie to lower source");
        read_expect(A_PRI_FAST, 32'h8000_0000, "R10 fast none");
        check_pins(1'b0, 1'b0, "R9 global off");
        bus_write(A_GLOBAL, 32'h1);
        check_pins(1'b0, 1'b0, "R9 host off");
        bus_write(A_HEN_IDX_SET, 32'd1);
        check_pins(1'b0, 1'b1, "R9 R12 normal line up");
        read_expect(A_HEN, 32'h2, "R9 host enable readback");
        src[9] = 1'b0; settle();
        read_expect(A_PRI_NORM, 32'hB, "R7 channel beats number");

        // Fast line
        bus_write(A_MAP_BASE + 12'h28, 32'h0F0F_0F01);
        src[40] = 1'b1; settle();
        read_expect(A_PRI_FAST, 32'h28, "R8 channel 1 to fast");
        check_pins(1'b0, 1'b1, "R9 fast host off");
        bus_write(A_HEN_IDX_SET, 32'd0);
        check_pins(1'b1, 1'b1, "R8 fast line up");
        bus_write(A_GLOBAL, 32'h0);
        check_pins(1'b0, 1'b0, "R9 global gates both");
        bus_write(A_GLOBAL, 32'h1);
        bus_write(A_HEN_IDX_CLR, 32'd1);
        check_pins(1'b1, 1'b0, "R9 host clear");

        bus_write(A_MAP_BASE + 12'h28, 32'h0F0F_0001);
        bus_write(A_EN_IDX_SET, 32'd41);
        src[41] = 1'b1; settle();
        read_expect(A_PRI_FAST, 32'h29, "R7 channel 0 over 1");

        bus_write(A_EN_BASE, 32'hFFFF_FFFF);
        read_expect(A_PRI_NORM, 32'h8000_0000, "R10 normal none");
        bus_write(A_EN_BASE + 12'h4, 32'hFFFF_FFFF);
        read_expect(A_PRI_FAST, 32'h8000_0000, "R10 fast none after clear");
        check_pins(1'b0, 1'b0, "R9 lines drop");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL reads missing: got %0d pending expected 0", exp_q.size());
        end
        summary();
    end
endmodule